// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words that sits between two clock domains. The producer side stores a word on a rising edge of its own clock when both of its write enables are high. The consumer side removes a word on a rising edge of its own clock when both of its read enables are high. The two clocks may be unrelated or the same net. Each side sees the boundary flag that concerns it in its own clock domain: full on the write side and empty on the read side. Both are active low.

Two more active-low flags give early warning. Almost-empty lives on the read side and almost-full on the write side, each compared against an offset that software or a controller can change. Offsets are written through the data input while the load control is high, in a cycle shaped like a write. The first such cycle sets the almost-empty offset, the next sets the almost-full offset, and further load cycles keep alternating between the two. Reset returns both offsets to seven and points the load sequence at almost-empty again.

Top module: `dcfifo_progflags`

## Requirements
- R1: When `ld` is low, `wr_en` and `wr_en_b` are both high and `full_n` is high, a rising `wr_clk` edge stores `din`. Words are returned on `dout` in the order they were stored, including when the two clocks have unrelated periods.
- R2: A rising edge with either write enable low stores nothing. A rising `rd_clk` edge with either read enable low removes nothing and leaves `dout` unchanged.
- R3: `full_n` is low exactly while the write side sees DEPTH stored words. Write attempts while `full_n` is low are ignored. `full_n` returns high within three `wr_clk` edges after a read frees a slot.
- R4: `empty_n` is low exactly while the read side sees no stored words. Read attempts while it is low leave `dout` unchanged and remove nothing.
- R5: While `rst_n` is low and after it rises, the outputs are `empty_n`=0, `full_n`=1, `aempty_n`=0, `afull_n`=1 and `dout`=0.
- R6: `aempty_n` is low while the word count seen by the read side is less than or equal to the almost-empty offset. The offset is seven after reset.
- R7: `afull_n` is low while the number of free locations seen by the write side is less than or equal to the almost-full offset. The offset is seven after reset.
- R8: A rising `wr_clk` edge with `ld` and `wr_en` both high stores nothing into the queue. It copies `din` into an offset register instead. Successive load cycles go to almost-empty, then almost-full, then almost-empty again, and so on. Reset restores both offsets to seven and the sequence to almost-empty.
- R9: Pointers cross between domains in Gray code. At most one bit of a pointer changes per edge. A stored word makes `empty_n` high by the third `rd_clk` rising edge after the storing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| din | input | 9 | Data word, or offset value during a load cycle |
| wr_en | input | 1 | First write enable; also qualifies load cycles |
| wr_en_b | input | 1 | Second write enable |
| ld | input | 1 | Offset-load control |
| rd_en | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| dout | output | 9 | Last word read |
| full_n | output | 1 | Active-low full, write domain |
| empty_n | output | 1 | Active-low empty, read domain |
| afull_n | output | 1 | Active-low almost-full, write domain |
| aempty_n | output | 1 | Active-low almost-empty, read domain |

## Verification
The hardest state to reach is the third load cycle. It must land back on the almost-empty offset, and that can only be seen through a flag once the queue holds a count that separates the old offset from the new one. The bench gets there in several steps. It first loads small offsets and proves each one by filling the queue word by word across its threshold. This includes a near-full fill for almost-full. After draining, it issues a third load with a large value and refills to a count that lies between the two almost-empty candidates. It also drives full and empty repeatedly to show that blocked attempts leave the read-out order intact. Finally it streams concurrently with unrelated clock periods.

// File: rtl/dcfifo_progflags.sv
module dcfifo_progflags #(
  parameter int DEPTH   = 512,
  parameter int WIDTH   = 9,
  parameter int DEF_OFS = 7
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             wr_en,
  input  logic             wr_en_b,
  input  logic             ld,
  input  logic             rd_en,
  input  logic             rd_en_b,
  output logic [WIDTH-1:0] dout,
  output logic             full_n,
  output logic             empty_n,
  output logic             afull_n,
  output logic             aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [WIDTH-1:0] DEF_C = WIDTH'(DEF_OFS);

  function automatic logic [CW-1:0] to_gray(input logic [CW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CW-1:0] to_bin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];

  // write domain
  logic [CW-1:0]    wbin, wgray, rg_s1, rg_s2;
  logic [WIDTH-1:0] ae_w, af_w;
  logic             ld_sel;
  logic [CW-1:0]    wcount, wfree;
  logic             wr_go, ld_go;

  assign wcount  = wbin - to_bin(rg_s2);
  assign wfree   = DEPTH_C - wcount;
  assign full_n  = (wcount != DEPTH_C);
  assign afull_n = !(wfree <= CW'(af_w));
  assign ld_go   = ld && wr_en;
  assign wr_go   = !ld && wr_en && wr_en_b && full_n;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      rg_s1  <= '0;
      rg_s2  <= '0;
      ae_w   <= DEF_C;
      af_w   <= DEF_C;
      ld_sel <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
      if (ld_go) begin
        if (ld_sel) af_w <= din;
        else        ae_w <= din;
        ld_sel <= !ld_sel;
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= din;

  // read domain
  logic [CW-1:0]    rbin, rgray, wg_s1, wg_s2;
  logic [WIDTH-1:0] ae_s1, ae_s2, dout_q;
  logic [CW-1:0]    rcount;
  logic             rd_go;

  assign rcount   = to_bin(wg_s2) - rbin;
  assign empty_n  = (rcount != '0);
  assign aempty_n = !(rcount <= CW'(ae_s2));
  assign rd_go    = rd_en && rd_en_b && empty_n;
  assign dout     = dout_q;

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wg_s1  <= '0;
      wg_s2  <= '0;
      ae_s1  <= DEF_C;
      ae_s2  <= DEF_C;
      dout_q <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      ae_s1 <= ae_w;
      ae_s2 <= ae_s1;
      if (rd_go) begin
        dout_q <= mem[rbin[AW-1:0]];
        rbin   <= rbin + 1'b1;
        rgray  <= to_gray(rbin + 1'b1);
      end
    end
endmodule

// File: rtl/dcfifo_progflags_chk.sv
module dcfifo_progflags_chk #(
  parameter int CW    = 10,
  parameter int WIDTH = 9
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_en_b,
  input logic             ld,
  input logic             rd_en,
  input logic             rd_en_b,
  input logic [WIDTH-1:0] dout,
  input logic             full_n,
  input logic             empty_n,
  input logic             afull_n,
  input logic             aempty_n,
  input logic [CW-1:0]    wbin,
  input logic [CW-1:0]    rbin,
  input logic [CW-1:0]    wgray,
  input logic [CW-1:0]    rgray
);
  a_r1_write_advances: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full_n && wr_en && wr_en_b && !ld) |=> (wbin == CW'($past(wbin) + 1'b1)));

  a_r2_read_needs_both: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(rd_en && rd_en_b) |=> ($stable(rbin) && $stable(dout)));

  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && wr_en && wr_en_b && !ld) |=> $stable(wbin));

  a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && rd_en && rd_en_b) |=> ($stable(rbin) && $stable(dout)));

  a_r6_empty_is_aempty: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  a_r7_full_is_afull: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  a_r8_load_stores_nothing: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (ld && wr_en) |=> $stable(wbin));

  a_r9_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_en |=> $onehot0(wgray ^ $past(wgray)));

  a_r9_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_en |=> $onehot0(rgray ^ $past(rgray)));
endmodule

bind dcfifo_progflags dcfifo_progflags_chk #(.CW(CW), .WIDTH(WIDTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .wr_en(wr_en), .wr_en_b(wr_en_b), .ld(ld), .rd_en(rd_en), .rd_en_b(rd_en_b),
  .dout(dout), .full_n(full_n), .empty_n(empty_n), .afull_n(afull_n),
  .aempty_n(aempty_n), .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray)
);

// File: tb/dcfifo_progflags_bench.sv
`timescale 1ns/1ps
module dcfifo_progflags_bench;
  localparam real CLK_PERIOD = 10.0;
  localparam real RD_PERIOD  = 14.0;
  localparam int  DEPTH      = 512;

  logic       wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [8:0] din = '0;
  logic       wr_en = 0, wr_en_b = 0, ld = 0, rd_en = 0, rd_en_b = 0;
  logic [8:0] dout;
  logic       full_n, empty_n, afull_n, aempty_n;

  int n_chk = 0, n_fail = 0;
  bit [8:0] q[$];
  int seed_v = 5;

  dcfifo_progflags #(.DEPTH(DEPTH)) u_dcfifo_progflags (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wr_en(wr_en), .wr_en_b(wr_en_b), .ld(ld), .rd_en(rd_en), .rd_en_b(rd_en_b),
    .dout(dout), .full_n(full_n), .empty_n(empty_n),
    .afull_n(afull_n), .aempty_n(aempty_n));

  always #(CLK_PERIOD / 2.0) wr_clk = ~wr_clk;
  initial begin
    #1.3;
    forever #(RD_PERIOD / 2.0) rd_clk = ~rd_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit [8:0] nextv();
    seed_v = (seed_v * 37 + 11) % 509;
    return 9'(seed_v);
  endfunction

  task automatic do_write(input bit [8:0] v);
    bit acc;
    @(negedge wr_clk);
    acc = full_n;
    din = v; wr_en = 1; wr_en_b = 1;
    @(negedge wr_clk);
    wr_en = 0; wr_en_b = 0;
    if (acc) q.push_back(v);
  endtask

  task automatic do_read(input string req, output bit got);
    bit [8:0] e;
    @(negedge rd_clk);
    got = empty_n;
    rd_en = 1; rd_en_b = 1;
    @(negedge rd_clk);
    rd_en = 0; rd_en_b = 0;
    if (got) begin
      e = q.pop_front();
      chk(dout == e, req, dout, e);
    end
  endtask

  task automatic do_load(input bit [8:0] v);
    @(negedge wr_clk);
    din = v; ld = 1; wr_en = 1;
    @(negedge wr_clk);
    ld = 0; wr_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic drain(input string req);
    bit got;
    int guard = 0;
    while (q.size() > 0 && guard < 4 * DEPTH) begin
      do_read(req, got);
      guard++;
    end
    chk(q.size() == 0, req, q.size(), 0);
  endtask

  task automatic t_reset();
    rst_n = 0; wr_en = 0; wr_en_b = 0; ld = 0; rd_en = 0; rd_en_b = 0;
    q.delete();
    repeat (3) @(negedge wr_clk);
    chk({empty_n, full_n, aempty_n, afull_n} == 4'b0101, "R5 flags in reset",
        {empty_n, full_n, aempty_n, afull_n}, 4'b0101);
    rst_n = 1;
    settle();
    chk({empty_n, full_n, aempty_n, afull_n} == 4'b0101, "R5 flags after reset",
        {empty_n, full_n, aempty_n, afull_n}, 4'b0101);
    chk(dout == 9'h0, "R5 dout", dout, 0);
  endtask

  task automatic t_enables();
    bit got;
    @(negedge wr_clk);
    din = 9'h155; wr_en = 1; wr_en_b = 0;
    @(negedge wr_clk);
    wr_en = 1; wr_en_b = 0; din = 9'h0AA;
    @(negedge wr_clk);
    wr_en = 0; din = 9'h0F0; wr_en_b = 1;
    @(negedge wr_clk);
    wr_en_b = 0;
    settle();
    chk(empty_n == 0, "R2 half write enable stores nothing", empty_n, 0);
    do_write(9'h123);
    repeat (2) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(empty_n == 1, "R9 visible by third rd edge", empty_n, 1);
    @(negedge rd_clk);
    rd_en = 1; rd_en_b = 0;
    @(negedge rd_clk);
    rd_en = 0; rd_en_b = 1;
    @(negedge rd_clk);
    rd_en_b = 0;
    chk(dout == 9'h0 && empty_n == 1, "R2 half read enable removes nothing", dout, 0);
    do_read("R1 single word", got);
    chk(got == 1, "R1 word present", got, 1);
    @(negedge rd_clk);
    chk(empty_n == 0, "R4 empty after last read", empty_n, 0);
  endtask

  task automatic t_aempty_default();
    bit got;
    for (int i = 0; i < 7; i++) do_write(nextv());
    settle();
    chk(aempty_n == 0, "R6 seven words almost empty", aempty_n, 0);
    do_write(nextv());
    settle();
    chk(aempty_n == 1, "R6 eight words not almost empty", aempty_n, 1);
    do_read("R6 order", got);
    chk(aempty_n == 0, "R6 back to seven", aempty_n, 0);
    drain("R6 drain");
  endtask

  task automatic t_full();
    bit [8:0] last;
    bit got;
    for (int i = 0; i < DEPTH - 8; i++) do_write(nextv());
    settle();
    chk(afull_n == 1, "R7 eight free not almost full", afull_n, 1);
    do_write(nextv());
    chk(afull_n == 0, "R7 seven free almost full", afull_n, 0);
    chk(full_n == 1, "R3 not yet full", full_n, 1);
    for (int i = 0; i < 7; i++) do_write(nextv());
    chk(full_n == 0, "R3 full at depth", full_n, 0);
    chk(q.size() == DEPTH, "R3 model count", q.size(), DEPTH);
    do_write(9'h1AA);
    chk(q.size() == DEPTH, "R3 write at full not accepted", q.size(), DEPTH);
    do_read("R3 first read after full", got);
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk);
    chk(full_n == 1, "R3 full clears after read", full_n, 1);
    drain("R3 order through full");
    settle();
    last = dout;
    chk(empty_n == 0, "R4 empty after drain", empty_n, 0);
    @(negedge rd_clk);
    rd_en = 1; rd_en_b = 1;
    repeat (2) @(negedge rd_clk);
    rd_en = 0; rd_en_b = 0;
    chk(dout == last && empty_n == 0, "R4 read at empty ignored", dout, last);
  endtask

  task automatic t_load();
    bit got;
    do_load(9'd3);
    do_load(9'd5);
    settle();
    for (int i = 0; i < 3; i++) do_write(nextv());
    settle();
    chk(aempty_n == 0, "R8 ae offset 3 three words", aempty_n, 0);
    do_write(nextv());
    settle();
    chk(aempty_n == 1, "R8 ae offset 3 four words", aempty_n, 1);
    for (int i = 0; i < 4; i++) do_read("R8 loads store no data", got);
    settle();
    chk(empty_n == 0, "R8 only data words queued", empty_n, 0);
    for (int i = 0; i < DEPTH - 6; i++) do_write(nextv());
    settle();
    chk(afull_n == 1, "R8 af offset 5 six free", afull_n, 1);
    do_write(nextv());
    chk(afull_n == 0, "R8 af offset 5 five free", afull_n, 0);
    drain("R8 drain");
    do_load(9'd20);
    settle();
    for (int i = 0; i < 12; i++) do_write(nextv());
    settle();
    chk(aempty_n == 0, "R8 third load wraps to ae", aempty_n, 0);
    drain("R8 drain two");
    t_reset();
    for (int i = 0; i < 8; i++) do_write(nextv());
    settle();
    chk(aempty_n == 1, "R8 reset restores ae seven", aempty_n, 1);
    drain("R8 drain three");
  endtask

  task automatic t_stream();
    int n = 300;
    fork
      begin
        int cnt = 0;
        while (cnt < n) begin
          if (full_n) begin do_write(nextv()); cnt++; end
          else @(negedge wr_clk);
          if (cnt % 3 == 0) @(negedge wr_clk);
        end
      end
      begin
        int cnt = 0;
        bit got;
        while (cnt < n) begin
          do_read("R1 stream order", got);
          if (got) cnt++;
          if (cnt % 5 == 0) @(negedge rd_clk);
        end
      end
    join
    chk(q.size() == 0, "R1 stream all read", q.size(), 0);
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 100000.0);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_enables();
    t_aempty_default();
    t_full();
    t_load();
    t_stream();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule